// File: doc/BRIEF.md
# Flow-Through Burst Synchronous SRAM

This block models a single-port synchronous SRAM in which every access is split across two clock cycles. Address, direction, byte-lane enables and a load/advance control are captured on a rising edge. The data for that command moves in the following cycle: read data leaves the array through a flow-through path with no output register, and write data is taken at the edge that closes the data cycle. A write is followed directly by a read, or a read by a write, with no idle cycle between them.

A two-bit burst stepper lets one loaded address deliver four words. The low two address bits then move in either linear order or interleaved (XOR) order, and the sequence wraps after the fourth word. A three-input chip select, a clock-enable suspend and an asynchronous output enable give the usual controls of a pipelined memory. The bidirectional data bus is modelled as separate `wdata` and `rdata` ports plus a `drive_en` output that tells the surrounding logic when the memory would drive the bus.

The word is `LANES` lanes of 9 bits each (36 bits by default). The depth is a parameter that must be a power of two and at least 4.

Top module: `flowthru_burst_sram`

## Requirements
- R1: A load (`load_n`=0) with the chip selected and `wr_n`=1 makes `drive_en` high in the cycle after the sampling edge. `rdata` then shows the word at the loaded address in that same cycle, with no extra register stage.
- R2: A selected load with `wr_n`=0 writes, at the edge that ends the following cycle, the `wdata` bits of every lane i whose `lane_we_n[i]` is 0. Lane i is bits [9i+8:9i]. Lanes with `lane_we_n[i]`=1 keep their old contents, and `drive_en` stays low during a write data cycle.
- R3: With `load_n`=1 during a burst, `addr` and `wr_n` are ignored. The burst keeps the direction that was fixed at its load.
- R4: With `burst_ilv`=0, the k-th advance (k=1,2,3,...) uses low address bits (start+k) mod 4. The upper bits stay at the loaded value, so the sequence wraps after four words.
- R5: With `burst_ilv`=1, the k-th advance uses low address bits start XOR (k mod 4).
- R6: In a burst write, `lane_we_n` is sampled again on every advance edge and applies to that word only.
- R7: The chip is selected only when `cs_a_n`=0, `cs_b_n`=0 and `cs_c`=1. A load cycle with any select false ends the burst. The transfer already pending from the previous command still completes, and `drive_en` is low from the next cycle on.
- R8: `load_n`=1 while no burst is active is a no-op: no transfer follows and `drive_en` is low.
- R9: When `clk_en_n`=1 at an edge, that edge has no effect. Outputs are unchanged and a pending write is not committed until the next enabled edge, which uses `wdata` from that edge.
- R10: `oe_n`=1 forces `drive_en` low at once, without waiting for a clock edge.
- R11: A read loaded at the edge that commits a write to the same address returns the newly written bytes.
- R12: After reset `drive_en` is low and no burst is active, so an advance is a no-op.
- R13: `lane_we_n` has no effect on read commands: a read never changes the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control pipeline |
| clk_en_n | input | 1 | Active-low clock enable; high suspends the block |
| cs_a_n | input | 1 | Active-low chip select |
| cs_b_n | input | 1 | Active-low chip select |
| cs_c | input | 1 | Active-high chip select |
| load_n | input | 1 | 0 loads a new command, 1 advances the burst |
| wr_n | input | 1 | 0 write, 1 read (sampled at load) |
| lane_we_n | input | LANES | Active-low byte-lane write enables |
| addr | input | $clog2(DEPTH) | Word address |
| burst_ilv | input | 1 | 0 linear, 1 interleaved burst order |
| oe_n | input | 1 | Asynchronous active-low output enable |
| wdata | input | 9*LANES | Write data for the current data cycle |
| rdata | output | 9*LANES | Flow-through read data |
| drive_en | output | 1 | High when read data would be driven onto the bus |

## Verification
Every command result is due in the cycle after the edge that sampled it. The bench therefore updates its reference at each rising edge and compares `drive_en` and `rdata` at the next falling edge, when the flow-through read has settled. A write becomes visible from the edge that closes its data cycle, so a read loaded at that same edge is compared against the new bytes. A suspended edge leaves the expected state untouched. Output-enable gating has no clock delay, so that check is made one time step after `oe_n` changes, in the middle of a cycle.

// File: rtl/fbsram_pkg.sv
`timescale 1ns/1ps
package fbsram_pkg;
   localparam int LANE_W = 9;
   localparam int STEP_W = 2;

   // offset of a burst word within its aligned group of four
   function automatic logic [STEP_W-1:0] burst_offset(input logic [STEP_W-1:0] start,
                                                      input logic [STEP_W-1:0] step,
                                                      input logic              ilv);
      return ilv ? (start ^ step) : (start + step);
   endfunction
endpackage

// File: rtl/fbsram_cmd_pipe.sv
`timescale 1ns/1ps
module fbsram_cmd_pipe
   import fbsram_pkg::*;
#(
   parameter int AW    = 10,
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic             sel,
   input  logic             load,
   input  logic             wr,
   input  logic [LANES-1:0] lane_we,
   input  logic [AW-1:0]    addr,
   input  logic             ilv,
   output logic             st_valid,
   output logic             st_wr,
   output logic [AW-1:0]    st_addr,
   output logic [LANES-1:0] st_lanes
);
   logic              burst_on;
   logic              op_wr;
   logic [AW-1:0]     base;
   logic [STEP_W-1:0] step;
   logic [STEP_W-1:0] step_nx;

   always_comb step_nx = step + 2'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_on <= 1'b0;
         op_wr    <= 1'b0;
         base     <= '0;
         step     <= '0;
         st_valid <= 1'b0;
         st_wr    <= 1'b0;
         st_addr  <= '0;
         st_lanes <= '0;
      end else if (ce) begin
         if (load) begin
            if (sel) begin
               burst_on <= 1'b1;
               op_wr    <= wr;
               base     <= addr;
               step     <= '0;
               st_valid <= 1'b1;
               st_wr    <= wr;
               st_addr  <= addr;
               st_lanes <= wr ? lane_we : '0;
            end else begin
               burst_on <= 1'b0;
               st_valid <= 1'b0;
               st_wr    <= 1'b0;
               st_lanes <= '0;
            end
         end else if (burst_on) begin
            step     <= step_nx;
            st_valid <= 1'b1;
            st_wr    <= op_wr;
            st_addr  <= {base[AW-1:STEP_W], burst_offset(base[STEP_W-1:0], step_nx, ilv)};
            st_lanes <= op_wr ? lane_we : '0;
         end else begin
            st_valid <= 1'b0;
            st_wr    <= 1'b0;
            st_lanes <= '0;
         end
      end
   end

   p_load_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && load && sel && !wr) |=> (st_valid && !st_wr && st_addr == $past(addr)));
   p_burst_keeps_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !load && burst_on) |=> (st_valid && st_wr == $past(op_wr)));
   p_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && load && !sel) |=> (!st_valid && !burst_on));
   p_noop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !load && !burst_on) |=> !st_valid);
   p_suspend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> ($stable(st_valid) && $stable(st_addr) && $stable(burst_on) && $stable(step)));
endmodule

// File: rtl/fbsram_lane_array.sv
`timescale 1ns/1ps
module fbsram_lane_array
   import fbsram_pkg::*;
#(
   parameter int DEPTH = 1024,
   parameter int LANES = 4,
   localparam int AW   = $clog2(DEPTH),
   localparam int WW   = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             ce,
   input  logic             commit,
   input  logic [AW-1:0]    addr,
   input  logic [LANES-1:0] lanes,
   input  logic [WW-1:0]    wdata,
   output logic [WW-1:0]    rdata
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (ce && commit && lanes[i])
            mem[addr] <= wdata[i*LANE_W +: LANE_W];
      end
      assign rdata[i*LANE_W +: LANE_W] = mem[addr];
   end
endmodule

// File: rtl/flowthru_burst_sram.sv
`timescale 1ns/1ps
module flowthru_burst_sram
   import fbsram_pkg::*;
#(
   parameter int DEPTH = 1024,
   parameter int LANES = 4,
   localparam int AW   = $clog2(DEPTH),
   localparam int WW   = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en_n,
   input  logic             cs_a_n,
   input  logic             cs_b_n,
   input  logic             cs_c,
   input  logic             load_n,
   input  logic             wr_n,
   input  logic [LANES-1:0] lane_we_n,
   input  logic [AW-1:0]    addr,
   input  logic             burst_ilv,
   input  logic             oe_n,
   input  logic [WW-1:0]    wdata,
   output logic [WW-1:0]    rdata,
   output logic             drive_en
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 4");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end

   logic             ce;
   logic             sel;
   logic             st_valid;
   logic             st_wr;
   logic [AW-1:0]    st_addr;
   logic [LANES-1:0] st_lanes;

   assign ce  = ~clk_en_n;
   assign sel = ~cs_a_n & ~cs_b_n & cs_c;

   fbsram_cmd_pipe #(.AW(AW), .LANES(LANES)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce       (ce),
      .sel      (sel),
      .load     (~load_n),
      .wr       (~wr_n),
      .lane_we  (~lane_we_n),
      .addr     (addr),
      .ilv      (burst_ilv),
      .st_valid (st_valid),
      .st_wr    (st_wr),
      .st_addr  (st_addr),
      .st_lanes (st_lanes)
   );

   fbsram_lane_array #(.DEPTH(DEPTH), .LANES(LANES)) u_array (
      .clk    (clk),
      .ce     (ce),
      .commit (st_valid & st_wr),
      .addr   (st_addr),
      .lanes  (st_lanes),
      .wdata  (wdata),
      .rdata  (rdata)
   );

   assign drive_en = st_valid & ~st_wr & ~oe_n;

   p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !drive_en);
   p_suspend_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en_n && !oe_n && $past(!oe_n)) |=> ($stable(drive_en) || oe_n));
endmodule

// File: tb/flowthru_burst_sram_test.sv
`timescale 1ns/1ps
module flowthru_burst_sram_test;
   localparam int DEPTH = 1024;
   localparam int AW = 10;
   localparam int WW = 36;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clk_en_n = 1'b0, cs_a_n = 1'b1, cs_b_n = 1'b1, cs_c = 1'b0;
   logic load_n = 1'b1, wr_n = 1'b1, burst_ilv = 1'b0, oe_n = 1'b0;
   logic [3:0] lane_we_n = 4'hF;
   logic [AW-1:0] addr = '0;
   logic [WW-1:0] wdata = '0;
   logic [WW-1:0] rdata;
   logic drive_en;

   int n_chk = 0, n_fail = 0, dsel_rot = 0;

   // reference state
   logic [WW-1:0] mem_ref [DEPTH];
   logic [WW-1:0] known   [DEPTH];
   bit m_valid, m_wr, m_bon, m_opwr;
   int m_addr, m_base, m_k;
   logic [3:0] m_lanes;

   always #10 clk = ~clk;

   flowthru_burst_sram #(.DEPTH(DEPTH), .LANES(4)) uut (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
      .cs_c(cs_c), .load_n(load_n), .wr_n(wr_n), .lane_we_n(lane_we_n), .addr(addr),
      .burst_ilv(burst_ilv), .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .drive_en(drive_en));

   task automatic chk(input string tag, input string what, input logic [WW-1:0] act, input logic [WW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      bit selected;
      int s, off;
      if (clk_en_n) return;
      if (m_valid && m_wr)
         for (int i = 0; i < 4; i++)
            if (m_lanes[i]) begin
               mem_ref[m_addr][i*9 +: 9] = wdata[i*9 +: 9];
               known[m_addr][i*9 +: 9]   = '1;
            end
      selected = !cs_a_n && !cs_b_n && cs_c;
      if (!load_n) begin
         if (selected) begin
            m_bon = 1; m_opwr = !wr_n; m_base = int'(addr); m_k = 0;
            m_valid = 1; m_wr = !wr_n; m_addr = int'(addr); m_lanes = ~lane_we_n;
         end else begin
            m_bon = 0; m_valid = 0; m_wr = 0;
         end
      end else if (m_bon) begin
         m_k = (m_k + 1) % 4;
         s = m_base % 4;
         off = burst_ilv ? (s ^ m_k) : ((s + m_k) % 4);
         m_addr = (m_base / 4) * 4 + off;
         m_valid = 1; m_wr = m_opwr; m_lanes = ~lane_we_n;
      end else begin
         m_valid = 0; m_wr = 0;
      end
   endtask

   task automatic compare(input string tag);
      bit exp_drv;
      logic [WW-1:0] mk;
      exp_drv = m_valid && !m_wr && !oe_n;
      chk(tag, "drive_en", {35'd0, drive_en}, {35'd0, exp_drv});
      if (exp_drv) begin
         mk = known[m_addr];
         if (mk != '0) chk(tag, "rdata", rdata & mk, mem_ref[m_addr] & mk);
      end
   endtask

   // one clock: drive at falling edge, model at rising edge, compare at next falling edge
   task automatic step(input string tag, input bit cen, input bit sel, input bit ld_n,
                       input bit w_n, input logic [3:0] ln, input int a, input logic [WW-1:0] wd);
      clk_en_n = cen;
      if (sel) begin cs_a_n = 0; cs_b_n = 0; cs_c = 1; end
      else begin
         cs_a_n = (dsel_rot == 0); cs_b_n = (dsel_rot == 1); cs_c = (dsel_rot != 2);
         dsel_rot = (dsel_rot + 1) % 3;
      end
      load_n = ld_n; wr_n = w_n; lane_we_n = ln; addr = AW'(a); wdata = wd;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare(tag);
   endtask

   function automatic logic [WW-1:0] pat(input int a, input int salt);
      return {4'(salt), 32'(a * 32'h01010101 + salt * 32'h10203)};
   endfunction

   initial begin : watchdog
      #(20 * 200000);
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin mem_ref[i] = '0; known[i] = '0; end
      m_valid = 0; m_wr = 0; m_bon = 0; m_opwr = 0; m_addr = 0; m_base = 0; m_k = 0; m_lanes = 0;
      repeat (3) @(negedge clk);
      compare("R12");
      rst_n = 1'b1;
      // R12: advance right after reset is a no-op
      step("R12", 0, 1, 1, 1, 4'h0, 5, '0);
      step("R8", 0, 0, 1, 0, 4'h0, 5, '0);

      // R2: full write, then partial lane write, then read back
      step("R2", 0, 1, 0, 0, 4'h0, 10, '0);
      step("R2", 0, 1, 0, 0, 4'b1010, 10, 36'hAAAAAAAAA);
      step("R2", 0, 1, 0, 1, 4'hF, 10, 36'h155555555);
      step("R2", 0, 1, 1, 1, 4'hF, 0, '0);
      // R11: write then read same address immediately
      step("R11", 0, 1, 0, 0, 4'h0, 20, '0);
      step("R11", 0, 1, 0, 1, 4'hF, 20, 36'h9_1234_5678);
      step("R1", 0, 1, 0, 1, 4'hF, 10, '0);
      // R13: read with lane enables active must not change memory
      step("R13", 0, 1, 0, 1, 4'h0, 20, 36'hF_FFFF_FFFF);
      step("R13", 0, 1, 0, 1, 4'h0, 20, 36'h0);
      step("R13", 0, 0, 0, 1, 4'hF, 0, '0);

      // fill 64..71 with distinct words
      for (int a = 64; a < 72; a++) step("R2", 0, 1, 0, 0, 4'h0, a, (a == 64) ? '0 : pat(a - 1, 3));
      step("R2", 0, 0, 0, 1, 4'hF, 0, pat(71, 3));

      // R4 / R5: burst reads from all four start offsets, six advances to see the wrap
      for (int o = 0; o < 2; o++) begin
         burst_ilv = o[0];
         for (int s = 0; s < 4; s++) begin
            step(o ? "R5" : "R4", 0, 1, 0, 1, 4'hF, 64 + s, '0);
            for (int k = 0; k < 6; k++) step(o ? "R5" : "R4", 0, 1, 1, k[0], 4'h0, 300 + k, '0);
         end
      end
      burst_ilv = 1'b0;
      step("R8", 0, 0, 0, 1, 4'hF, 0, '0);

      // R6 / R3: burst write with per-word lanes; addr and wr_n ignored on advance
      step("R6", 0, 1, 0, 0, 4'h0, 130, '0);
      step("R6", 0, 1, 1, 1, 4'b1110, 500, pat(130, 7));
      step("R6", 0, 1, 1, 1, 4'b0111, 501, pat(131, 7));
      step("R6", 0, 1, 1, 1, 4'h0, 502, pat(128, 7));
      step("R6", 0, 0, 0, 1, 4'hF, 0, pat(129, 7));
      step("R3", 0, 1, 0, 1, 4'hF, 130, '0);
      for (int k = 0; k < 3; k++) step("R3", 0, 1, 1, 0, 4'h0, 600 + k, '0);

      // R7: deselect right after read load; pending read still shown, then bus off
      step("R7", 0, 1, 0, 1, 4'hF, 66, '0);
      step("R7", 0, 0, 0, 1, 4'hF, 0, '0);
      step("R8", 0, 1, 1, 1, 4'hF, 0, '0);
      // R7: write then deselect; the pending write still commits
      step("R7", 0, 1, 0, 0, 4'h0, 77, '0);
      step("R7", 0, 0, 0, 1, 4'hF, 0, 36'h3_C0FF_EE00);
      step("R7", 0, 1, 0, 1, 4'hF, 77, '0);
      // R7: deselect ends a burst, advances afterwards are no-ops
      step("R7", 0, 1, 0, 1, 4'hF, 68, '0);
      step("R7", 0, 1, 1, 1, 4'hF, 0, '0);
      step("R7", 0, 0, 0, 1, 4'hF, 0, '0);
      step("R8", 0, 1, 1, 1, 4'hF, 0, '0);

      // R9: suspend during read data cycle holds the output
      step("R9", 0, 1, 0, 1, 4'hF, 69, '0);
      step("R9", 1, 0, 0, 0, 4'h0, 3, '0);
      step("R9", 1, 1, 0, 0, 4'h0, 4, '0);
      // R9: suspend during write data cycle, data taken at next enabled edge
      step("R9", 0, 1, 0, 0, 4'h0, 90, '0);
      step("R9", 1, 1, 0, 1, 4'hF, 91, 36'h1_1111_1111);
      step("R9", 0, 1, 0, 1, 4'hF, 90, 36'h2_2222_2222);
      step("R9", 0, 0, 0, 1, 4'hF, 0, '0);

      // R10: output enable gates the bus without a clock edge
      step("R10", 0, 1, 0, 1, 4'hF, 90, '0);
      #2 oe_n = 1'b1;
      #1 chk("R10", "drive_en", {35'd0, drive_en}, 36'd0);
      oe_n = 1'b0;
      #1 chk("R10", "drive_en", {35'd0, drive_en}, 36'd1);
      @(negedge clk);

      // R1: mixed random traffic over a small window
      for (int n = 0; n < 400; n++) begin
         automatic int r = int'($urandom % 16);
         burst_ilv = (n / 50) % 2 == 1;
         oe_n = ($urandom % 10) == 0;
         step("R1", r == 0, r != 1, r >= 9, r < 5, 4'($urandom), int'($urandom % 32),
              {4'($urandom), 32'($urandom)});
      end
      oe_n = 1'b0;

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule